// File: doc/BRIEF.md
# Dual-Channel Single-Slope PWM Timer

This block is an 8-bit timer. One counter ramps from zero up to a ceiling and then falls straight back to zero. Two compare channels, A and B, watch this shared ramp. Each channel turns the ramp into a pulse-width-modulated waveform. The counter moves only on ticks from a built-in clock divider. The divide ratio can be 1, 8, 64, 256 or 1024, or the divider can be stopped. With the ceiling at 255, each waveform repeats every 256·N clock cycles.

Software loads a new compare value through a one-cycle write strobe. The value waits in a holding register and becomes active only when the counter wraps, so a period never sees a half-applied duty cycle. Each channel has a 2-bit output mode: disconnected, toggle (channel A only, with the alternate-ceiling bit set), non-inverting or inverting. An output-enable bit gates each raw waveform register onto its pin. There are three sticky event flags: overflow, match A and match B. Writing a one to a flag's clear bit clears it. When the alternate-ceiling bit is set, the ceiling comes from channel A's active compare value. Channel A in toggle mode then gives a square wave with an even duty.

All control inputs are plain levels or one-cycle strobes. No data stream flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm2ch_timer`

## Requirements
- R1: On each tick the counter goes up by one. On the tick where it equals the ceiling, it goes to 0 instead. The ceiling is 255 while `alt_wave`=0 and is channel A's active compare value while `alt_wave`=1. After reset the counter is 0.
- R2: `presc_sel` sets the tick rate: 1 gives a tick every clock, 2 every 8, 3 every 64, 4 every 256 and 5 every 1024. Codes 0, 6 and 7 stop the counter.
- R3: Mode 2 (non-inverting) sets the waveform on the wrap tick and clears it on the match tick. For active compare value C, `wave` is then 1 exactly while `count` <= C, seen in the same cycle as `count`.
- R4: Mode 3 (inverting) clears the waveform on the wrap tick and sets it on the match tick. `wave` is then 1 exactly while `count` > C.
- R5: `flags[0]` (overflow) is set by the tick on which the counter is at the ceiling. It reads 1 from the cycle where `count` shows 0.
- R6: A compare write goes into a holding register. It is copied to the active value on the next wrap tick. A write in the same cycle as a wrap tick waits for the following wrap.
- R7: `flags[1]` and `flags[2]` are set by a tick on which `count` equals the active compare value of channel A or channel B.
- R8: In mode 1 with `alt_wave`=1, channel A's waveform toggles on every match. Because the ceiling then equals C, it flips once per period of C+1 ticks.
- R9: `pin` is 0 whenever `oe`=0, in mode 0, in mode 1 on channel A with `alt_wave`=0, and in mode 1 on channel B. Channel B's waveform never changes in mode 1. Otherwise `pin` follows `wave`.
- R10: C=0 in mode 2 gives a one-tick high spike per 256-tick period, and in mode 3 a one-tick low spike. C=255 holds mode 2 constantly high and mode 3 constantly low.
- R11: The flags stay set until a one is written to the matching bit of `flag_clr`. A set event and a clear in the same cycle leave the flag set. All flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 3 | Tick rate select (0 stop, 1/8/64/256/1024 for codes 1..5) |
| alt_wave | input | 1 | Ceiling from channel A compare; enables A toggle mode |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| oe_a | input | 1 | Channel A pin enable |
| oe_b | input | 1 | Channel B pin enable |
| cmp_a_wr | input | 1 | Write strobe for channel A compare |
| cmp_a_data | input | 8 | Channel A compare value |
| cmp_b_wr | input | 1 | Write strobe for channel B compare |
| cmp_b_data | input | 8 | Channel B compare value |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 match A, bit2 match B |
| count | output | 8 | Counter value |
| wave_a | output | 1 | Channel A raw waveform register |
| wave_b | output | 1 | Channel B raw waveform register |
| pin_a | output | 1 | Channel A gated pin value |
| pin_b | output | 1 | Channel B gated pin value |
| flags | output | 3 | Sticky flags: bit0 overflow, bit1 match A, bit2 match B |

## Verification
Two pairs of functions can land in one cycle. First, the wrap tick sets the overflow flag while a write-one-to-clear targets that same flag. Second, the wrap tick copies the compare holding register while software writes a new compare value. The bench runs at divide-by-1 and drives the clear or the write at the exact cycle where `count` reads 255. It then checks that the overflow flag stays set. It also checks that the previous compare value governs one more full period before the new one appears in the waveform. An exhaustive sweep walks every compare value through both PWM polarities and checks every cycle of each period.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;

  typedef enum logic [1:0] {
    CM_OFF    = 2'd0,
    CM_TOGGLE = 2'd1,
    CM_NONINV = 2'd2,
    CM_INV    = 2'd3
  } cmp_mode_e;

  localparam int NUM_CH  = 2;
  localparam int NUM_FLG = NUM_CH + 1;

  // Divider select to log2 of the division ratio; unused codes map to 0
  // and are treated as "stopped" by the prescaler.
  function automatic logic [3:0] sel_to_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 4'd0;
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic sel_runs(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

endpackage

// File: rtl/pwm2ch_prescaler.sv
module pwm2ch_prescaler
  import pwm2ch_pkg::*;
#(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PS_W-1:0] div_cnt;
  logic [PS_W-1:0] mask;
  logic [3:0]      shift;
  logic            run;

  assign run   = sel_runs(sel);
  assign shift = sel_to_shift(sel);

  // Low 'shift' bits set: tick when those bits of the running count are all ones.
  always_comb begin
    for (int i = 0; i < PS_W; i++) begin
      mask[i] = (i < int'(shift));
    end
  end

  assign tick = run && ((div_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm2ch_counter.sv
module pwm2ch_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         at_top
);

  assign at_top = tick && (cnt == top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == top) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm2ch_channel.sv
module pwm2ch_channel
  import pwm2ch_pkg::*;
#(
  parameter int W          = 8,
  parameter bit CAN_TOGGLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         at_top,
  input  logic [W-1:0] cnt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  cmp_mode_e    mode,
  input  logic         alt_wave,
  input  logic         out_en,
  output logic [W-1:0] cmp_act,
  output logic         wave,
  output logic         pin,
  output logic         match
);

  logic [W-1:0] cmp_buf;
  logic         toggle_ok;
  logic         connected;
  logic         wave_nxt;

  // Holding register and active copy; copy uses the value held before any
  // write landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_en)  cmp_buf <= wr_data;
      if (at_top) cmp_act <= cmp_buf;
    end
  end

  assign match     = tick && (cnt == cmp_act);
  assign toggle_ok = CAN_TOGGLE && alt_wave && (mode == CM_TOGGLE);
  assign connected = (mode == CM_NONINV) || (mode == CM_INV) || toggle_ok;

  // Wrap action has priority over match action so boundary values give
  // constant levels.
  always_comb begin
    wave_nxt = wave;
    unique case (mode)
      CM_NONINV: begin
        if (at_top)     wave_nxt = 1'b1;
        else if (match) wave_nxt = 1'b0;
      end
      CM_INV: begin
        if (at_top)     wave_nxt = 1'b0;
        else if (match) wave_nxt = 1'b1;
      end
      CM_TOGGLE: begin
        if (toggle_ok && match) wave_nxt = ~wave;
      end
      default: wave_nxt = wave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= wave_nxt;
  end

  assign pin = out_en && connected && wave;

endmodule

// File: rtl/pwm2ch_flags.sv
module pwm2ch_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

endmodule

// File: rtl/pwm2ch_timer.sv
module pwm2ch_timer
  import pwm2ch_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       presc_sel,
  input  logic             alt_wave,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             oe_a,
  input  logic             oe_b,
  input  logic             cmp_a_wr,
  input  logic [CNT_W-1:0] cmp_a_data,
  input  logic             cmp_b_wr,
  input  logic [CNT_W-1:0] cmp_b_data,
  input  logic [2:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             wave_a,
  output logic             wave_b,
  output logic             pin_a,
  output logic             pin_b,
  output logic [2:0]       flags
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic             tick;
  logic             at_top;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] act_a;
  logic [CNT_W-1:0] act_b;

  logic [NUM_CH-1:0] ch_wr;
  logic [NUM_CH-1:0] ch_oe;
  logic [NUM_CH-1:0] ch_wave;
  logic [NUM_CH-1:0] ch_pin;
  logic [NUM_CH-1:0] ch_match;
  logic [CNT_W-1:0]  ch_data [NUM_CH];
  logic [CNT_W-1:0]  ch_act  [NUM_CH];
  cmp_mode_e         ch_mode [NUM_CH];

  assign ch_wr      = {cmp_b_wr, cmp_a_wr};
  assign ch_oe      = {oe_b, oe_a};
  assign ch_data[0] = cmp_a_data;
  assign ch_data[1] = cmp_b_data;
  assign ch_mode[0] = cmp_mode_e'(mode_a);
  assign ch_mode[1] = cmp_mode_e'(mode_b);

  assign act_a   = ch_act[0];
  assign act_b   = ch_act[1];
  assign top_val = alt_wave ? act_a : MAX_VAL;

  pwm2ch_prescaler #(.PS_W(PS_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (presc_sel),
    .tick (tick)
  );

  pwm2ch_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .top   (top_val),
    .cnt   (count),
    .at_top(at_top)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm2ch_channel #(.W(CNT_W), .CAN_TOGGLE(i == 0)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .at_top  (at_top),
      .cnt     (count),
      .wr_en   (ch_wr[i]),
      .wr_data (ch_data[i]),
      .mode    (ch_mode[i]),
      .alt_wave(alt_wave),
      .out_en  (ch_oe[i]),
      .cmp_act (ch_act[i]),
      .wave    (ch_wave[i]),
      .pin     (ch_pin[i]),
      .match   (ch_match[i])
    );
  end

  assign wave_a = ch_wave[0];
  assign wave_b = ch_wave[1];
  assign pin_a  = ch_pin[0];
  assign pin_b  = ch_pin[1];

  pwm2ch_flags #(.N(NUM_FLG)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ({ch_match, at_top}),
    .clr  (flag_clr),
    .flags(flags)
  );

endmodule

// File: rtl/pwm2ch_timer_chk.sv
module pwm2ch_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] top_val,
  input logic [CNT_W-1:0] act_a,
  input logic [CNT_W-1:0] act_b,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       flags,
  input logic [2:0]       flag_clr,
  input logic [1:0]       mode_b,
  input logic             oe_a,
  input logic             oe_b,
  input logic             pin_a,
  input logic             pin_b,
  input logic             wave_b
);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> (count == '0));

  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != top_val) |=> (count == CNT_W'($past(count) + 1'b1)));

  a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> flags[0]);

  a_r11_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !(tick && count == top_val)) |=> !flags[0]);

  a_r6_active_a_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && count == top_val) |=> $stable(act_a));

  a_r6_active_b_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && count == top_val) |=> $stable(act_b));

  a_r7_match_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == act_a) |=> flags[1]);

  a_r7_match_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == act_b) |=> flags[2]);

  a_r9_gate_a: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_a |-> !pin_a);

  a_r9_gate_b: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_b |-> !pin_b);

  a_r9_b_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'd1) |=> $stable(wave_b));

  a_r9_b_mode1_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'd1) |-> !pin_b);

endmodule

bind pwm2ch_timer pwm2ch_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .top_val (top_val),
  .act_a   (act_a),
  .act_b   (act_b),
  .count   (count),
  .flags   (flags),
  .flag_clr(flag_clr),
  .mode_b  (mode_b),
  .oe_a    (oe_a),
  .oe_b    (oe_b),
  .pin_a   (pin_a),
  .pin_b   (pin_b),
  .wave_b  (wave_b)
);

// File: tb/pwm2ch_timer_tb_top.sv
module pwm2ch_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] presc_sel;
  logic       alt_wave;
  logic [1:0] mode_a, mode_b;
  logic       oe_a, oe_b;
  logic       cmp_a_wr, cmp_b_wr;
  logic [7:0] cmp_a_data, cmp_b_data;
  logic [2:0] flag_clr;
  logic [7:0] count;
  logic       wave_a, wave_b, pin_a, pin_b;
  logic [2:0] flags;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  pwm2ch_timer dut_i (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .alt_wave(alt_wave),
    .mode_a(mode_a), .mode_b(mode_b), .oe_a(oe_a), .oe_b(oe_b),
    .cmp_a_wr(cmp_a_wr), .cmp_a_data(cmp_a_data),
    .cmp_b_wr(cmp_b_wr), .cmp_b_data(cmp_b_data),
    .flag_clr(flag_clr), .count(count), .wave_a(wave_a), .wave_b(wave_b),
    .pin_a(pin_a), .pin_b(pin_b), .flags(flags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_count(input logic [7:0] v);
    do @(negedge clk); while (count !== v);
  endtask

  task automatic write_a(input logic [7:0] v);
    cmp_a_data = v;
    cmp_a_wr   = 1'b1;
    @(negedge clk);
    cmp_a_wr   = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog (all): got %0d cycles expected < 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int bad_c, bad_a, bad_b, first_a, exp_a;
    logic [7:0] cur_a, cur_b, prev;
    logic w0, wb0;
    bit seen_high;

    rst_n = 1'b0; presc_sel = 3'd0; alt_wave = 1'b0;
    mode_a = 2'd0; mode_b = 2'd0; oe_a = 1'b0; oe_b = 1'b0;
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cmp_a_data = '0; cmp_b_data = '0;
    flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check(count == 0, "R1", "count after reset", count, 0);
    check(flags == 0, "R11", "flags after reset", flags, 0);
    check({wave_a, wave_b, pin_a, pin_b} == 0, "R9", "outputs after reset",
          {wave_a, wave_b, pin_a, pin_b}, 0);

    // R1 / R2: divide-by-1 sawtooth with ceiling 255
    presc_sel = 3'd1; mode_a = 2'd2; mode_b = 2'd3; oe_a = 1'b1; oe_b = 1'b1;
    prev = count; bad_c = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (count !== ((prev == 8'd255) ? 8'd0 : prev + 8'd1)) bad_c++;
      prev = count;
    end
    check(bad_c == 0, "R1", "sawtooth step errors at divide-by-1", bad_c, 0);

    // R3 R4 R10 R6: exhaustive sweep of compare values, every cycle checked
    wait_count(8'd0);
    cur_a = 8'd0; cur_b = 8'd0;
    for (int p = 0; p <= 256; p++) begin
      bad_c = 0; bad_a = 0; bad_b = 0; first_a = -1;
      for (int k = 0; k < 256; k++) begin
        if (count !== k[7:0]) bad_c++;
        exp_a = (k <= int'(cur_a)) ? 1 : 0;
        if (wave_a !== exp_a[0] || pin_a !== wave_a) begin
          bad_a++;
          if (first_a < 0) first_a = k;
        end
        if (wave_b !== (k > int'(cur_b)) || pin_b !== wave_b) bad_b++;
        cmp_a_wr   = (k == 100) && (p < 256);
        cmp_b_wr   = (k == 100) && (p < 256);
        cmp_a_data = p[7:0];
        cmp_b_data = p[7:0] ^ 8'hA5;
        @(negedge clk);
      end
      check(bad_c == 0, "R1", "count sequence in sweep period", bad_c, 0);
      check(bad_a == 0, (cur_a == 0 || cur_a == 255) ? "R10" : "R3",
            $sformatf("mode2 wave mismatches C=%0d first at %0d", cur_a, first_a),
            bad_a, 0);
      check(bad_b == 0, (cur_b == 0 || cur_b == 255) ? "R10" : "R4",
            $sformatf("mode3 wave mismatches C=%0d", cur_b), bad_b, 0);
      if (p < 256) begin
        cur_a = p[7:0];
        cur_b = p[7:0] ^ 8'hA5;
      end
    end
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    // Now count reads 0; active A=255, active B=0x5A.

    // R11 / R5: clear, ceiling set, set-versus-clear collision
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
    check(flags == 0, "R11", "flags after write-one-to-clear", flags, 0);
    wait_count(8'd254);
    check(flags[0] == 0, "R5", "overflow before ceiling tick", flags[0], 0);
    @(negedge clk);
    check(flags[0] == 0, "R5", "overflow while count at ceiling", flags[0], 0);
    flag_clr = 3'b001;            // same cycle as the ceiling tick
    @(negedge clk);
    flag_clr = 3'b000;
    check(flags[0] == 1, "R11", "set wins over same-cycle clear", flags[0], 1);
    check(flags[1] == 1, "R7", "match A flag at C=255", flags[1], 1);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    check(flags[0] == 0, "R11", "overflow cleared by write-one", flags[0], 0);
    check(flags[1] == 1, "R11", "match A untouched by bit0 clear", flags[1], 1);
    flag_clr = 3'b110;
    @(negedge clk);
    flag_clr = 3'b000;
    check(flags[2:1] == 0, "R11", "match flags cleared", flags[2:1], 0);
    wait_count(8'h5A);
    check(flags[2] == 0, "R7", "match B before its tick", flags[2], 0);
    @(negedge clk);
    check(flags[2] == 1, "R7", "match B after tick at C=0x5A", flags[2], 1);

    // R6: write coinciding with the ceiling tick waits one more period
    wait_count(8'd100);
    write_a(8'd200);
    wait_count(8'd0);
    wait_count(8'd255);
    write_a(8'd7);                // lands with the copy at the ceiling
    wait_count(8'd150);
    check(wave_a == 1, "R6", "old compare 200 still governs", wave_a, 1);
    wait_count(8'd0);
    wait_count(8'd150);
    check(wave_a == 0, "R6", "new compare 7 applied one period later", wave_a, 0);

    // R8 / R1: toggle with ceiling from channel A compare = 9
    write_a(8'd9);
    wait_count(8'd0);
    alt_wave = 1'b1; mode_a = 2'd1; mode_b = 2'd1;
    wait_count(8'd0);
    w0 = wave_a; wb0 = wave_b;
    bad_c = 0; bad_a = 0; bad_b = 0;
    for (int per = 0; per < 6; per++) begin
      for (int k = 0; k < 10; k++) begin
        if (count !== k[7:0]) bad_c++;
        if (wave_a !== (w0 ^ per[0]) || pin_a !== wave_a) bad_a++;
        if (pin_b !== 1'b0 || wave_b !== wb0) bad_b++;
        @(negedge clk);
      end
    end
    check(bad_c == 0, "R1", "count wraps at ceiling 9 from compare A", bad_c, 0);
    check(bad_a == 0, "R8", "channel A toggles once per period", bad_a, 0);
    check(bad_b == 0, "R9", "channel B mode 1 holds and pin low", bad_b, 0);

    // R9: mode 1 on A without alt is disconnected
    alt_wave = 1'b0;
    w0 = wave_a; bad_a = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pin_a !== 1'b0 || wave_a !== w0) bad_a++;
    end
    check(bad_a == 0, "R9", "A mode 1 without alt: pin low, no toggle", bad_a, 0);

    // R9: output enable off while the waveform runs
    mode_a = 2'd2; oe_a = 1'b0; bad_a = 0; seen_high = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (wave_a) seen_high = 1'b1;
      if (pin_a !== 1'b0) bad_a++;
    end
    check(bad_a == 0, "R9", "pin low while oe_a=0", bad_a, 0);
    check(seen_high, "R9", "wave_a active behind disabled pin", seen_high, 1);
    mode_a = 2'd0; oe_a = 1'b1; bad_a = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pin_a !== 1'b0) bad_a++;
    end
    check(bad_a == 0, "R9", "pin low in mode 0", bad_a, 0);

    // R2: divider ratios and stop codes
    for (int s = 2; s <= 5; s++) begin
      int ratio;
      ratio = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      presc_sel = s[2:0];
      prev = count;
      do begin @(negedge clk); end while (count === prev);
      for (int rep = 0; rep < 2; rep++) begin
        int gap;
        gap = 0;
        prev = count;
        do begin @(negedge clk); gap++; end while (count === prev);
        check(gap == ratio, "R2", $sformatf("tick spacing for code %0d", s), gap, ratio);
      end
    end
    foreach (presc_sel[i]) begin end
    for (int s = 0; s < 3; s++) begin
      logic [2:0] code;
      code = (s == 0) ? 3'd0 : (s == 1) ? 3'd6 : 3'd7;
      presc_sel = code;
      @(negedge clk);
      prev = count; bad_c = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (count !== prev) bad_c++;
      end
      check(bad_c == 0, "R2", $sformatf("counter stopped for code %0d", code), bad_c, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule